// File: doc/BRIEF.md
# Interrupt Status and Enable Register Set

This block holds the interrupt bookkeeping of a USB host controller behind a small word-addressed register bus. Event pulses from the controller core set sticky pending bits in a status register. Software acknowledges an event by writing 1 to its status bit. Writing 0 leaves the bit alone.

The enable mask has no plain read-modify-write address. Software sets enable bits with a write of ones to one address and clears them with a write of ones to a second address. A read of either address returns the current mask. The top bit of the mask is a master enable that gates every source. The block drives a single interrupt line. The line is high while the master enable is set and at least one pending bit is also enabled.

Reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `intr_reg_set`

## Requirements
- R1: After reset the status and enable registers are all zero, every address reads 0, and `irq` is low.
- R2: A high `evtIn` bit at a source position sets the status bit at the same position on the next clock edge. The source positions are bits 0 to 6 and bit 30: overrun, done-list write-back, frame start, resume, fatal error, frame-count rollover, hub change and ownership change.
- R3: A write at the status address (word address 0) clears each status bit whose `wrData` bit is 1. Bits written with 0 keep their value.
- R4: A write at the enable-set address (word address 1) sets each enable bit whose `wrData` bit is 1. Bits written with 0 keep their value.
- R5: A write at the enable-clear address (word address 2) clears each enable bit whose `wrData` bit is 1. Bits written with 0 keep their value.
- R6: Reads at word address 1 and word address 2 both return the same current enable mask.
- R7: `irq` is high exactly when enable bit 31 (the master enable) is set and some source bit is set in both status and enable.
- R8: If a source event and a write-1 clear of the same status bit fall in the same cycle, the bit is set after that edge.
- R9: Non-source bit positions ignore events and writes and always read 0. This includes status bit 31. In the enable register, bit 31 is stored in addition to the source positions.
- R10: Word addresses 3 and above read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address of the access |
| wrEn | input | 1 | Write strobe for the current address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for the current address, combinational |
| evtIn | input | DATA_W | Event pulses from the controller core, one per source position |
| irq | output | 1 | Interrupt request line |

## Verification
The bound checker watches four things on every cycle:
- a source event always leaves its status bit set, even when a clear hits the same bit;
- a status write never leaves a bit set that was written with 1 and had no event;
- enable-set and enable-clear writes move exactly the bits written, and the mask is stable when neither address is written;
- the interrupt line stays low while the master enable is clear.

The bench's scenarios cover the rest: the exact readback at every address, the equality of the two enable readbacks, the inertness of unused bit positions and unmapped addresses, and the interrupt line tracking changes in both masks.

// File: rtl/intr_regs_pkg.sv
package intr_regs_pkg;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_ENABLE = 2'd2
  } rdSel_e;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic   clrStatus;
    logic   setEnable;
    logic   clrEnable;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/intr_reg_ctrl.sv
module intr_reg_ctrl
  import intr_regs_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int ENSET_ADDR  = 1,
  parameter int ENCLR_ADDR  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output regStrobe_t        stb
);

  localparam logic [ADDR_W-1:0] StatusA = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] EnSetA  = ADDR_W'(ENSET_ADDR);
  localparam logic [ADDR_W-1:0] EnClrA  = ADDR_W'(ENCLR_ADDR);

  always_comb begin
    stb = '{clrStatus: 1'b0, setEnable: 1'b0, clrEnable: 1'b0, rdSel: RD_NONE};
    if (addr == StatusA) begin
      stb.rdSel     = RD_STATUS;
      stb.clrStatus = wrEn;
    end else if (addr == EnSetA) begin
      stb.rdSel     = RD_ENABLE;
      stb.setEnable = wrEn;
    end else if (addr == EnClrA) begin
      stb.rdSel     = RD_ENABLE;
      stb.clrEnable = wrEn;
    end
  end

endmodule

// File: rtl/intr_reg_dp.sv
module intr_reg_dp
  import intr_regs_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] SRC_MASK   = 32'h4000_007F,
  parameter int                MASTER_BIT = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] evtIn,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] enableQ,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam logic [DATA_W-1:0] EN_MASK = SRC_MASK | (DATA_W'(1) << MASTER_BIT);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (SRC_MASK[i]) begin : g_stat
      // An event takes priority over a clear in the same cycle
      always_ff @(posedge clk) begin
        if (!rstN)                          statusQ[i] <= 1'b0;
        else if (evtIn[i])                  statusQ[i] <= 1'b1;
        else if (stb.clrStatus && wrData[i]) statusQ[i] <= 1'b0;
      end
    end else begin : g_noStat
      assign statusQ[i] = 1'b0;
    end

    if (EN_MASK[i]) begin : g_en
      always_ff @(posedge clk) begin
        if (!rstN)                          enableQ[i] <= 1'b0;
        else if (stb.setEnable && wrData[i]) enableQ[i] <= 1'b1;
        else if (stb.clrEnable && wrData[i]) enableQ[i] <= 1'b0;
      end
    end else begin : g_noEn
      assign enableQ[i] = 1'b0;
    end
  end

  logic [DATA_W-1:0] pendVec;
  assign pendVec = statusQ & enableQ & SRC_MASK;
  assign irq     = enableQ[MASTER_BIT] & (|pendVec);

  always_comb begin
    unique case (stb.rdSel)
      RD_STATUS: rdData = statusQ;
      RD_ENABLE: rdData = enableQ;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/intr_reg_set.sv
module intr_reg_set
  import intr_regs_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 32,
  parameter int                STATUS_ADDR = 0,
  parameter int                ENSET_ADDR  = 1,
  parameter int                ENCLR_ADDR  = 2,
  parameter logic [DATA_W-1:0] SRC_MASK    = 32'h4000_007F,
  parameter int                MASTER_BIT  = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] evtIn,
  output logic              irq
);

  regStrobe_t        stb;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] enableQ;

  intr_reg_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR),
    .ENSET_ADDR(ENSET_ADDR), .ENCLR_ADDR(ENCLR_ADDR)
  ) u_ctrl (
    .addr(addr), .wrEn(wrEn), .stb(stb)
  );

  intr_reg_dp #(
    .DATA_W(DATA_W), .SRC_MASK(SRC_MASK), .MASTER_BIT(MASTER_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .evtIn(evtIn),
    .statusQ(statusQ), .enableQ(enableQ), .rdData(rdData), .irq(irq)
  );

endmodule

// File: rtl/intr_reg_set_chk.sv
module intr_reg_set_chk #(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 32,
  parameter int                STATUS_ADDR = 0,
  parameter int                ENSET_ADDR  = 1,
  parameter int                ENCLR_ADDR  = 2,
  parameter logic [DATA_W-1:0] SRC_MASK    = 32'h4000_007F,
  parameter int                MASTER_BIT  = 31
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] evtIn,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] enableQ,
  input logic              irq
);

  localparam logic [DATA_W-1:0] EN_MASK = SRC_MASK | (DATA_W'(1) << MASTER_BIT);

  logic setWr, clrWr, statWr;
  assign statWr = wrEn && (addr == ADDR_W'(STATUS_ADDR));
  assign setWr  = wrEn && (addr == ADDR_W'(ENSET_ADDR));
  assign clrWr  = wrEn && (addr == ADDR_W'(ENCLR_ADDR));

  // R8 (and R2): an event always leaves its bit pending
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((evtIn & SRC_MASK) != '0) |=>
      ((statusQ & $past(evtIn & SRC_MASK)) == $past(evtIn & SRC_MASK)));

  // R3
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    statWr |=> ((statusQ & $past(wrData) & ~$past(evtIn)) == '0));

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    setWr |=> ((enableQ & $past(wrData & EN_MASK)) == $past(wrData & EN_MASK)));

  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> ((enableQ & $past(wrData)) == '0));

  // R10
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(setWr || clrWr) |=> $stable(enableQ));

  // R7
  master_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ[MASTER_BIT] |-> !irq);

endmodule

bind intr_reg_set intr_reg_set_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR),
  .ENSET_ADDR(ENSET_ADDR), .ENCLR_ADDR(ENCLR_ADDR),
  .SRC_MASK(SRC_MASK), .MASTER_BIT(MASTER_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .evtIn(evtIn), .statusQ(statusQ), .enableQ(enableQ), .irq(irq)
);

// File: tb/intr_reg_set_test.sv
module intr_reg_set_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] evtIn = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference state, behavioural
  bit [31:0] mStat = '0;
  bit [31:0] mEn = '0;
  localparam bit [31:0] SRC = 32'h4000_007F;

  always #5 clk = ~clk;

  intr_reg_set uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .evtIn(evtIn), .irq(irq)
  );

  function automatic bit [31:0] mRead(input int a);
    if (a == 0) return mStat;
    if (a == 1 || a == 2) return mEn;
    return 32'h0;
  endfunction

  function automatic bit mIrq();
    return mEn[31] && ((mStat & mEn & SRC) != 0);
  endfunction

  task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: apply inputs at negedge, update model, compare irq
  task automatic step(input int a, input bit w, input bit [31:0] d, input bit [31:0] e);
    addr = 4'(a); wrEn = w; wrData = d; evtIn = e;
    @(posedge clk);
    for (int b = 0; b < 32; b++) begin
      if (SRC[b]) begin
        if (e[b]) mStat[b] = 1'b1;
        else if (w && a == 0 && d[b]) mStat[b] = 1'b0;
      end
      if (SRC[b] || b == 31) begin
        if (w && a == 1 && d[b]) mEn[b] = 1'b1;
        else if (w && a == 2 && d[b]) mEn[b] = 1'b0;
      end
    end
    @(negedge clk);
    wrEn = 1'b0; evtIn = '0;
    check("R7 irq per cycle", 32'(irq), 32'(mIrq()));
  endtask

  task automatic readChk(input int a, input string tag);
    addr = 4'(a); wrEn = 1'b0;
    #1;
    check(tag, rdData, mRead(a));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readChk(0, "R1 status after reset");
    readChk(1, "R1 enable after reset");
    readChk(2, "R1 enable alias after reset");
    check("R1 irq after reset", 32'(irq), 32'h0);
    // R2, R9 events incl. unused positions and bit 31
    step(0, 0, 0, 32'hC000_0F7F);
    readChk(0, "R2 R9 status after events");
    check("R9 status bit31 reads 0", 32'(rdData[31]), 32'h0);
    // R3 clear by ones, zero write has no effect
    step(0, 1, 32'h0000_0005, 0);
    readChk(0, "R3 write-1 clear");
    step(0, 1, 32'h0, 0);
    readChk(0, "R3 write-0 no effect");
    // R4, R6 set enable
    step(1, 1, 32'h0000_0003, 0);
    readChk(1, "R4 enable set");
    readChk(2, "R6 alias read equal");
    check("R6 readback equality", mRead(1), mRead(2));
    // R7 master enable
    step(1, 1, 32'h8000_0000, 0);
    check("R7 irq with master", 32'(irq), 32'h1);
    // R5 clear enable
    step(2, 1, 32'h0000_0002, 0);
    readChk(1, "R5 enable clear");
    check("R7 irq off when no enabled pending", 32'(irq), 32'h0);
    // R8 event wins over clear
    step(1, 1, 32'h0000_0008, 0);
    step(0, 1, 32'h0000_0008, 32'h0000_0008);
    readChk(0, "R8 set wins over clear");
    // R9 unused enable bits ignore writes
    step(1, 1, 32'h3FFF_FF00, 0);
    readChk(2, "R9 unused enable bits");
    // R10 unmapped address
    readChk(3, "R10 unmapped read");
    step(3, 1, 32'hFFFF_FFFF, 0);
    step(9, 1, 32'hFFFF_FFFF, 0);
    readChk(0, "R10 status unchanged");
    readChk(1, "R10 enable unchanged");
    // Sweep of single events with all enabled
    step(1, 1, 32'hFFFF_FFFF, 0);
    step(0, 1, 32'hFFFF_FFFF, 0);
    for (int b = 0; b < 32; b++) begin
      step(0, 0, 0, 32'h1 << b);
      readChk(0, "R2 single event");
      step(0, 1, 32'h1 << b, 0);
    end
    // R5 master off gates irq
    step(0, 0, 0, 32'h4000_0000);
    step(2, 1, 32'h8000_0000, 0);
    check("R7 master off", 32'(irq), 32'h0);
    readChk(2, "R5 master cleared");
    // R1 reset again mid-run
    rstN = 1'b0;
    @(posedge clk); mStat = '0; mEn = '0;
    @(negedge clk); rstN = 1'b1;
    readChk(0, "R1 status after second reset");
    readChk(1, "R1 enable after second reset");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule